// File: doc/BRIEF.md
# Dual-Address I2C Slave Recognizer

This block sits on an I2C bus as a slave and decides whether the bus master is talking to it. It synchronizes SCL and SDA, finds START and STOP conditions, and shifts in the first byte that follows each START. The upper seven bits of that byte are compared against two independently programmable slave addresses. When an enabled address matches, the block pulls SDA low for the acknowledge clock and raises a match flag. The flag comes with an indication of which address hit and with the read/write bit of the frame.

Bit 0 of each address register is a format bit. Together the two format bits form a two-bit code. The code enables either address alone or both of them. It can also switch the port into a plain synchronous serial format in which no address is ever checked. Software reaches the registers through a small word interface. The second address register and the data register share one offset, and the interface enable bit chooses which of the two that offset reaches. Data-phase transfers, clock stretching and master operation are not part of this block.

Top module: `i2c_dual_addr_slave`

## Requirements
- R1: After reset, offset 0 (control) reads 0x00, offset 1 (first address) reads 0x00, offset 2 with the enable bit clear (second address) reads 0x01. The match flag and the SDA drive are low.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. SDA changes while SCL is low are data, and these events are seen on the two-flop synchronized copies of the pins.
- R3: The first frame after a START is sampled MSB first on SCL rising edges. Its bits 7..1 are compared with bits 7..1 of each address register. On a hit, sda_oe rises after the SCL falling edge that ends bit 8 and falls after the SCL falling edge that ends the 9th clock.
- R4: Format code {first bit0, second bit0} = 00 enables both addresses.
- R5: Format code 01 enables only the first address. A frame that matches only the second address is not acknowledged.
- R6: Format code 10 enables only the second address. A frame that matches only the first address is not acknowledged.
- R7: Format code 11 selects synchronous serial format. No address is checked, and sda_oe and match stay low.
- R8: match_sel is 0 when the first address matched and 1 when only the second did. If both match, the first wins.
- R9: When no enabled address matches, SDA is released during the acknowledge clock. Later frames are then ignored until the next START.
- R10: A STOP clears match and sda_oe. A repeated START clears match and restarts the address bit count, so a START in the middle of a frame begins a fresh frame.
- R11: Offset 2 reads and writes the second address register while control bit 0 is 0, and the data register while it is 1. Each register keeps its value while the other is being accessed.
- R12: On a match, rw_bit equals bit 0 of the address frame and holds until match clears.
- R13: While control bit 0 (enable) is 0, the recognizer stays idle and never drives SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND bus) |
| sda_oe | output | 1 | 1 = pull SDA low (acknowledge) |
| reg_addr | input | 2 | Register offset: 0 control, 1 first address, 2 second address or data |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| match | output | 1 | An enabled address was recognized in the current transfer |
| match_sel | output | 1 | 0 = first address hit, 1 = second address hit |
| rw_bit | output | 1 | Read/write bit of the recognized frame |

## Verification
The bound checker watches the acknowledge drive on every cycle. It checks that the drive only rises on an SCL falling edge and only together with a match, and that it never rises in serial format or while the interface is disabled. It also checks that STOP and START clear the match state one cycle later and that the first address wins when both hit. The bench scenarios show the things a per-cycle property cannot. These are the exact address comparison for each format code, the ignore-until-START behaviour after a miss, a restart in the middle of a frame, and the shared register offset switching with the enable bit.

// File: rtl/dual_addr_pkg.sv
package dual_addr_pkg;

  localparam int ADDR_BITS = 7;
  localparam int FRAME_BITS = ADDR_BITS + 1;
  localparam int REG_W = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_ACK,
    RX_OWNED,
    RX_IGNORE
  } rx_state_t;

  typedef struct packed {
    logic use_first;
    logic use_second;
    logic serial;
  } fmt_t;

  // Two format bits -> which addresses are live.
  function automatic fmt_t decode_fmt(input logic fs_first, input logic fs_second);
    fmt_t f;
    f.serial     = fs_first & fs_second;
    f.use_first  = ~fs_first;
    f.use_second = ~fs_second;
    return f;
  endfunction

  // Compare the address field of a frame with a register's address field.
  function automatic logic addr_hit(input logic [REG_W-1:0] frame,
                                    input logic [REG_W-1:0] slave_reg,
                                    input logic live);
    return live && (frame[REG_W-1:1] == slave_reg[REG_W-1:1]);
  endfunction

endpackage

// File: rtl/das_line_sync.sv
module das_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_prev;
  logic sda_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_evt = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_evt  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/das_reg_bank.sv
module das_reg_bank
  import dual_addr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             if_en,
  output logic [REG_W-1:0] addr_first,
  output logic [REG_W-1:0] addr_second
);

  localparam logic [1:0] OFS_CTRL   = 2'd0;
  localparam logic [1:0] OFS_FIRST  = 2'd1;
  localparam logic [1:0] OFS_SHARED = 2'd2;
  localparam logic [REG_W-1:0] SECOND_RST = REG_W'(1);

  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] first_q;
  logic [REG_W-1:0] second_q;
  logic [REG_W-1:0] data_q;

  assign if_en       = ctrl_q[0];
  assign addr_first  = first_q;
  assign addr_second = second_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      first_q  <= '0;
      second_q <= SECOND_RST;
      data_q   <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_CTRL:  ctrl_q  <= reg_wdata;
        OFS_FIRST: first_q <= reg_wdata;
        OFS_SHARED: begin
          if (ctrl_q[0]) data_q   <= reg_wdata;
          else           second_q <= reg_wdata;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_CTRL:   reg_rdata = ctrl_q;
      OFS_FIRST:  reg_rdata = first_q;
      OFS_SHARED: reg_rdata = ctrl_q[0] ? data_q : second_q;
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/das_addr_rx.sv
module das_addr_rx
  import dual_addr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [REG_W-1:0] addr_first,
  input  logic [REG_W-1:0] addr_second,
  output logic             serial_mode,
  output logic             frame_done,
  output logic             hit_first,
  output logic             hit_second,
  output logic             sda_oe,
  output logic             match,
  output logic             match_sel,
  output logic             rw_bit
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS);

  rx_state_t        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [REG_W-1:0] shift_q;
  fmt_t             fmt;

  assign fmt         = decode_fmt(addr_first[0], addr_second[0]);
  assign serial_mode = fmt.serial;
  assign frame_done  = (state_q == RX_ADDR) && (cnt_q == LAST);
  assign hit_first   = frame_done && !fmt.serial && addr_hit(shift_q, addr_first, fmt.use_first);
  assign hit_second  = frame_done && !fmt.serial && addr_hit(shift_q, addr_second, fmt.use_second);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      shift_q   <= '0;
      sda_oe    <= 1'b0;
      match     <= 1'b0;
      match_sel <= 1'b0;
      rw_bit    <= 1'b0;
    end else if (!enable || stop_evt) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      sda_oe  <= 1'b0;
      match   <= 1'b0;
    end else if (start_evt) begin
      state_q <= RX_ADDR;
      cnt_q   <= '0;
      sda_oe  <= 1'b0;
      match   <= 1'b0;
    end else begin
      case (state_q)
        RX_ADDR: begin
          if (scl_rise && cnt_q != LAST) begin
            shift_q <= {shift_q[REG_W-2:0], sda_s};
            cnt_q   <= cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST) begin
            if (hit_first || hit_second) begin
              state_q   <= RX_ACK;
              sda_oe    <= 1'b1;
              match     <= 1'b1;
              match_sel <= ~hit_first;
              rw_bit    <= shift_q[0];
            end else begin
              state_q <= RX_IGNORE;
            end
          end
        end
        RX_ACK: begin
          if (scl_fall) begin
            sda_oe  <= 1'b0;
            state_q <= RX_OWNED;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_dual_addr_slave.sv
module i2c_dual_addr_slave
  import dual_addr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             match,
  output logic             match_sel,
  output logic             rw_bit
);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic if_en;
  logic [REG_W-1:0] addr_first, addr_second;
  logic serial_mode, frame_done, hit_first, hit_second;

  das_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  das_reg_bank u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .if_en(if_en),
    .addr_first(addr_first), .addr_second(addr_second)
  );

  das_addr_rx u_rx (
    .clk(clk), .rst_n(rst_n), .enable(if_en), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt),
    .stop_evt(stop_evt), .addr_first(addr_first), .addr_second(addr_second),
    .serial_mode(serial_mode), .frame_done(frame_done), .hit_first(hit_first),
    .hit_second(hit_second), .sda_oe(sda_oe), .match(match),
    .match_sel(match_sel), .rw_bit(rw_bit)
  );

  logic unused_scl;
  assign unused_scl = scl_s ^ frame_done;

endmodule

// File: rtl/das_checker.sv
module das_checker (
  input logic clk,
  input logic rst_n,
  input logic if_en,
  input logic serial_mode,
  input logic scl_fall,
  input logic start_evt,
  input logic stop_evt,
  input logic hit_first,
  input logic sda_oe,
  input logic match,
  input logic match_sel
);

  // R3
  ack_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> match);

  // R3
  ack_on_scl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R7
  no_ack_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(!serial_mode));

  // R13
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en |=> !sda_oe);

  // R10
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!match && !sda_oe));

  // R10
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !match);

  // R8
  first_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(match) && $past(hit_first)) |-> !match_sel);

endmodule

bind i2c_dual_addr_slave das_checker u_chk (
  .clk(clk), .rst_n(rst_n), .if_en(if_en), .serial_mode(serial_mode),
  .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
  .hit_first(hit_first), .sda_oe(sda_oe), .match(match), .match_sel(match_sel)
);

// File: tb/i2c_dual_addr_slave_tb.sv
module i2c_dual_addr_slave_tb;

  localparam int Q = 20;
  localparam int NVEC = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic match, match_sel, rw_bit;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_dual_addr_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .match(match), .match_sel(match_sel), .rw_bit(rw_bit)
  );

  // {first reg, second reg, frame, ack, sel, rw}
  localparam logic [26:0] VEC [NVEC] = '{
    {8'hA0, 8'h66, 8'hA1, 1'b1, 1'b0, 1'b1},  // R4 first
    {8'hA0, 8'h66, 8'h66, 1'b1, 1'b1, 1'b0},  // R4 second
    {8'hA0, 8'h66, 8'h42, 1'b0, 1'b0, 1'b0},  // R9 miss
    {8'hA0, 8'h67, 8'hA0, 1'b1, 1'b0, 1'b0},  // R5 first live
    {8'hA0, 8'h67, 8'h67, 1'b0, 1'b0, 1'b0},  // R5 second off
    {8'hA1, 8'h66, 8'hA0, 1'b0, 1'b0, 1'b0},  // R6 first off
    {8'hA1, 8'h66, 8'h67, 1'b1, 1'b1, 1'b1},  // R6 second live
    {8'hA1, 8'h67, 8'hA0, 1'b0, 1'b0, 1'b0},  // R7 serial
    {8'hA1, 8'h67, 8'h66, 1'b0, 1'b0, 1'b0},  // R7 serial
    {8'h5A, 8'h5A, 8'h5A, 1'b1, 1'b0, 1'b0}   // R8 both hit
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(Q);
  endtask

  task automatic bus_bit(input logic b);
    sda_m = b; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_frame(input logic [7:0] f, output logic acked);
    for (int i = 7; i >= 0; i--) bus_bit(f[i]);
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q / 2);
    acked = ~sda_line;
    wait_q(Q / 2);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic setup(input logic [7:0] r1, input logic [7:0] r2);
    reg_write(2'd0, 8'h00);
    reg_write(2'd1, r1);
    reg_write(2'd2, r2);
    reg_write(2'd0, 8'h01);
  endtask

  initial begin
    logic [7:0] rd;
    logic acked;
    wait_q(4);
    // R1 reset state
    chk(match == 1'b0 && sda_oe == 1'b0, "R1 outputs idle", {match, sda_oe}, 0);
    rst_n = 1'b1;
    wait_q(2);
    reg_read(2'd0, rd); chk(rd == 8'h00, "R1 control reset", rd, 8'h00);
    reg_read(2'd1, rd); chk(rd == 8'h00, "R1 first reset", rd, 8'h00);
    reg_read(2'd2, rd); chk(rd == 8'h01, "R1 second reset", rd, 8'h01);

    // Vector walk: R2 R3 R4 R5 R6 R7 R8 R12
    for (int v = 0; v < NVEC; v++) begin
      setup(VEC[v][26:19], VEC[v][18:11]);
      bus_start();
      bus_frame(VEC[v][10:3], acked);
      chk(acked == VEC[v][2], $sformatf("R3 ack vec %0d", v), acked, VEC[v][2]);
      chk(match == VEC[v][2], $sformatf("R2 match vec %0d", v), match, VEC[v][2]);
      if (VEC[v][2]) begin
        chk(match_sel == VEC[v][1], $sformatf("R8 sel vec %0d", v), match_sel, VEC[v][1]);
        chk(rw_bit == VEC[v][0], $sformatf("R12 rw vec %0d", v), rw_bit, VEC[v][0]);
        chk(sda_oe == 1'b0, $sformatf("R3 release vec %0d", v), sda_oe, 0);
      end
      bus_stop();
      chk(match == 1'b0, $sformatf("R10 stop clears vec %0d", v), match, 0);
    end

    // R9 ignore until next START
    setup(8'hA0, 8'h66);
    bus_start();
    bus_frame(8'h42, acked);
    chk(acked == 1'b0, "R9 miss no ack", acked, 0);
    bus_frame(8'hA0, acked);
    chk(acked == 1'b0 && match == 1'b0, "R9 later frame ignored", acked, 0);
    bus_start();
    bus_frame(8'hA0, acked);
    chk(acked == 1'b1, "R9 next START recognised", acked, 1);
    // R10 repeated START clears match
    bus_start();
    chk(match == 1'b0, "R10 repeated start clears", match, 0);
    // R10 restart mid frame
    bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b0);
    bus_start();
    bus_frame(8'h66, acked);
    chk(acked == 1'b1 && match_sel == 1'b1, "R10 mid-frame restart", {acked, match_sel}, 2'b11);
    bus_stop();

    // R13 disabled
    reg_write(2'd0, 8'h00);
    bus_start();
    bus_frame(8'hA0, acked);
    chk(acked == 1'b0 && match == 1'b0, "R13 disabled ignores", acked, 0);
    bus_stop();

    // R11 shared offset
    reg_write(2'd2, 8'h5B);
    reg_write(2'd0, 8'h01);
    reg_write(2'd2, 8'hC3);
    reg_read(2'd2, rd); chk(rd == 8'hC3, "R11 data reg", rd, 8'hC3);
    reg_write(2'd0, 8'h00);
    reg_read(2'd2, rd); chk(rd == 8'h5B, "R11 second kept", rd, 8'h5B);
    reg_write(2'd0, 8'h01);
    reg_read(2'd2, rd); chk(rd == 8'hC3, "R11 data kept", rd, 8'hC3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule